// File: doc/BRIEF.md
# Basic Bit-Manipulation Execution Unit

This block is a purely combinational execution unit for the basic bit-manipulation operations of a scalar integer core. It takes two register operands, a 6-bit immediate rotate amount and a 5-bit operation code. It returns a register-width result and a flag that marks an operation code the current configuration does not implement. The parameter `XLEN` selects a 32-bit or a 64-bit datapath.

The unit covers the following groups:

- logic operations that invert the second operand;
- leading-zero count, trailing-zero count and population count;
- signed and unsigned minimum and maximum;
- rotates by a register amount and by an immediate amount;
- byte reversal and byte-wise OR-combine;
- narrow sign and zero extension.

In the 64-bit configuration the unit also provides word forms of the counts and rotates. A word form uses only the low 32 bits of its inputs and sign-extends its 32-bit result. Instruction decode and pipeline staging belong to the surrounding core.

No data is buffered, so there is no valid/ready stream at the edge. The core presents operands and an operation code and reads the result in the same cycle. The unit never applies back-pressure.

Top module: `bmu_alu`

## Requirements
- R1: Code 0 gives `a & ~b`, code 1 gives `a | ~b`, and code 2 gives `~(a ^ b)`, all at full width.
- R2: Code 3 counts leading zeros and code 4 counts trailing zeros of operand a. A zero operand yields XLEN.
- R3: Code 5 returns the number of set bits in operand a.
- R4: In the 64-bit configuration, codes 6, 7 and 8 are the leading-zero, trailing-zero and population counts of the low 32 bits of a. The upper input bits have no effect, and a zero low word yields 32 for codes 6 and 7.
- R5: Codes 9, 10, 11 and 12 return signed minimum, unsigned minimum, signed maximum and unsigned maximum of a and b.
- R6: Code 13 rotates a left and code 14 rotates a right, each by b modulo XLEN. Code 15 rotates a right by the immediate amount modulo XLEN.
- R7: In the 64-bit configuration, code 16 rotates the low word of a left and code 17 rotates it right, each by b modulo 32. Code 18 rotates the low word right by the immediate amount modulo 32. The 32-bit result is sign-extended, and the upper input bits have no effect.
- R8: Code 19 reverses the byte order of the whole operand. Code 20 sets each result byte to 0xFF when the matching byte of a is nonzero, and to 0x00 otherwise.
- R9: Code 21 sign-extends bits 7:0 of a. Code 22 sign-extends bits 15:0 of a. Code 23 zero-extends bits 15:0 of a.
- R10: Codes 24 to 31 raise `illegal_op` and return a zero result. In the 32-bit configuration codes 6, 7, 8, 16, 17 and 18 do the same. Every other code clears `illegal_op`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 5 | Operation code, listed in the requirements |
| src_a | input | XLEN | First operand |
| src_b | input | XLEN | Second operand, also the register rotate amount |
| shamt | input | 6 | Immediate rotate amount |
| result | output | XLEN | Operation result |
| illegal_op | output | 1 | Operation code not implemented in this configuration |

## Verification
Every result and the illegal flag are due in the same cycle as the inputs, because no register lies between any input and any output. The bench drives a new operation on the falling clock edge and samples one nanosecond later, well before the next rising edge. A 64-bit and a 32-bit instance are compared at that instant against reference functions. The bench mixes seeded random operands with directed corners: zero operands for the counts, rotate amounts at and beyond the width, sign-boundary min/max, and word codes on the 32-bit instance.

// File: rtl/bmu_pkg.sv
package bmu_pkg;

  typedef enum logic [4:0] {
    OP_ANDN  = 5'd0,
    OP_ORN   = 5'd1,
    OP_XNOR  = 5'd2,
    OP_CLZ   = 5'd3,
    OP_CTZ   = 5'd4,
    OP_CPOP  = 5'd5,
    OP_CLZW  = 5'd6,
    OP_CTZW  = 5'd7,
    OP_CPOPW = 5'd8,
    OP_MIN   = 5'd9,
    OP_MINU  = 5'd10,
    OP_MAX   = 5'd11,
    OP_MAXU  = 5'd12,
    OP_ROL   = 5'd13,
    OP_ROR   = 5'd14,
    OP_RORI  = 5'd15,
    OP_ROLW  = 5'd16,
    OP_RORW  = 5'd17,
    OP_RORIW = 5'd18,
    OP_REV8  = 5'd19,
    OP_ORCB  = 5'd20,
    OP_SEXTB = 5'd21,
    OP_SEXTH = 5'd22,
    OP_ZEXTH = 5'd23
  } bmu_op_e;

  localparam int WORD_W = 32;
  localparam int BYTE_W = 8;
  localparam int HALF_W = 16;

endpackage

// File: rtl/bmu_count.sv
module bmu_count #(
  parameter int W  = 64,
  parameter int CW = $clog2(W) + 1
) (
  input  logic [W-1:0]  data,
  output logic [CW-1:0] lead_zeros,
  output logic [CW-1:0] trail_zeros,
  output logic [CW-1:0] ones
);

  logic seen_lead;
  logic seen_trail;

  always_comb begin
    lead_zeros = CW'(W);
    seen_lead  = 1'b0;
    for (int i = W - 1; i >= 0; i--) begin
      if (!seen_lead && data[i]) begin
        lead_zeros = CW'(W - 1 - i);
        seen_lead  = 1'b1;
      end
    end
  end

  always_comb begin
    trail_zeros = CW'(W);
    seen_trail  = 1'b0;
    for (int i = 0; i < W; i++) begin
      if (!seen_trail && data[i]) begin
        trail_zeros = CW'(i);
        seen_trail  = 1'b1;
      end
    end
  end

  always_comb begin
    ones = '0;
    for (int i = 0; i < W; i++) begin
      ones = ones + CW'(data[i]);
    end
  end

  always_comb begin
    AST_COUNT_RANGE: assert ((lead_zeros <= CW'(W)) && (trail_zeros <= CW'(W)))
      else $error("count out of range"); // R2
    AST_ZERO_BOTH_FULL: assert ((lead_zeros == CW'(W)) == (trail_zeros == CW'(W)))
      else $error("lead/trail zero disagreement"); // R2
  end

endmodule

// File: rtl/bmu_rotate.sv
module bmu_rotate #(
  parameter int W  = 64,
  parameter int AW = $clog2(W)
) (
  input  logic [W-1:0]  data,
  input  logic [AW-1:0] left_amt,
  input  logic [AW-1:0] right_amt,
  output logic [W-1:0]  rot_left,
  output logic [W-1:0]  rot_right
);

  localparam int DW = 2 * W;

  logic [DW-1:0] dbl_left;
  logic [DW-1:0] dbl_right;

  always_comb begin
    dbl_left  = {data, data} << left_amt;
    dbl_right = {data, data} >> right_amt;
    rot_left  = dbl_left[DW-1:W];
    rot_right = dbl_right[W-1:0];
  end

endmodule

// File: rtl/bmu_bytes.sv
module bmu_bytes
  import bmu_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int NB   = XLEN / BYTE_W
) (
  input  logic [XLEN-1:0] data,
  output logic [XLEN-1:0] reversed,
  output logic [XLEN-1:0] or_comb,
  output logic [XLEN-1:0] sext_byte,
  output logic [XLEN-1:0] sext_half,
  output logic [XLEN-1:0] zext_half
);

  for (genvar g = 0; g < NB; g++) begin : g_lane
    assign reversed[g*BYTE_W +: BYTE_W] = data[(NB-1-g)*BYTE_W +: BYTE_W];
    assign or_comb[g*BYTE_W +: BYTE_W]  = {BYTE_W{|data[g*BYTE_W +: BYTE_W]}};
  end

  assign sext_byte = {{(XLEN-BYTE_W){data[BYTE_W-1]}}, data[BYTE_W-1:0]};
  assign sext_half = {{(XLEN-HALF_W){data[HALF_W-1]}}, data[HALF_W-1:0]};
  assign zext_half = {{(XLEN-HALF_W){1'b0}}, data[HALF_W-1:0]};

  always_comb begin
    AST_REV_POP: assert ($countones(reversed) == $countones(data))
      else $error("byte reversal changed bit count"); // R8
    AST_ORCB_ZERO: assert ((data == '0) == (or_comb == '0))
      else $error("or-combine zero mismatch"); // R8
  end

endmodule

// File: rtl/bmu_alu.sv
module bmu_alu
  import bmu_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [4:0]      op_sel,
  input  logic [XLEN-1:0] src_a,
  input  logic [XLEN-1:0] src_b,
  input  logic [5:0]      shamt,
  output logic [XLEN-1:0] result,
  output logic            illegal_op
);

  localparam int  AW       = $clog2(XLEN);
  localparam int  CW       = AW + 1;
  localparam int  WAW      = $clog2(WORD_W);
  localparam int  WCW      = WAW + 1;
  localparam bit  HAS_WORD = (XLEN == 64);

  bmu_op_e op;
  assign op = bmu_op_e'(op_sel);

  // full-width counts
  logic [CW-1:0] f_lz, f_tz, f_pop;
  bmu_count #(.W(XLEN), .CW(CW)) u_count_full (
    .data(src_a), .lead_zeros(f_lz), .trail_zeros(f_tz), .ones(f_pop)
  );

  // full-width rotates; right amount picks register or immediate
  logic [AW-1:0]   f_right_amt;
  logic [XLEN-1:0] f_rol, f_ror;
  assign f_right_amt = (op == OP_RORI) ? shamt[AW-1:0] : src_b[AW-1:0];
  bmu_rotate #(.W(XLEN), .AW(AW)) u_rot_full (
    .data(src_a), .left_amt(src_b[AW-1:0]), .right_amt(f_right_amt),
    .rot_left(f_rol), .rot_right(f_ror)
  );

  // byte and extension network
  logic [XLEN-1:0] b_rev, b_orc, b_sxb, b_sxh, b_zxh;
  bmu_bytes #(.XLEN(XLEN)) u_bytes (
    .data(src_a), .reversed(b_rev), .or_comb(b_orc),
    .sext_byte(b_sxb), .sext_half(b_sxh), .zext_half(b_zxh)
  );

  // word-form datapath, present only for the wide configuration
  logic [XLEN-1:0] w_clz, w_ctz, w_pop, w_rol, w_ror;

  if (HAS_WORD) begin : g_word
    logic [WCW-1:0]    lz, tz, pc;
    logic [WAW-1:0]    r_amt;
    logic [WORD_W-1:0] rl, rr;

    bmu_count #(.W(WORD_W), .CW(WCW)) u_count_word (
      .data(src_a[WORD_W-1:0]), .lead_zeros(lz), .trail_zeros(tz), .ones(pc)
    );

    assign r_amt = (op == OP_RORIW) ? shamt[WAW-1:0] : src_b[WAW-1:0];
    bmu_rotate #(.W(WORD_W), .AW(WAW)) u_rot_word (
      .data(src_a[WORD_W-1:0]), .left_amt(src_b[WAW-1:0]), .right_amt(r_amt),
      .rot_left(rl), .rot_right(rr)
    );

    assign w_clz = XLEN'(lz);
    assign w_ctz = XLEN'(tz);
    assign w_pop = XLEN'(pc);
    assign w_rol = {{(XLEN-WORD_W){rl[WORD_W-1]}}, rl};
    assign w_ror = {{(XLEN-WORD_W){rr[WORD_W-1]}}, rr};

    always_comb begin
      if ((op == OP_ROLW || op == OP_RORW || op == OP_RORIW) && !illegal_op) begin
        AST_WORD_SEXT: assert (result[XLEN-1:WORD_W] == {(XLEN-WORD_W){result[WORD_W-1]}})
          else $error("word rotate not sign-extended"); // R7
      end
      if (op == OP_CLZW || op == OP_CTZW) begin
        AST_WORD_COUNT_RANGE: assert (result <= XLEN'(WORD_W))
          else $error("word count above 32"); // R4
      end
    end
  end else begin : g_no_word
    assign w_clz = '0;
    assign w_ctz = '0;
    assign w_pop = '0;
    assign w_rol = '0;
    assign w_ror = '0;
  end

  // min / max
  logic            lt_s, lt_u;
  logic [XLEN-1:0] mn_s, mn_u, mx_s, mx_u;
  always_comb begin
    lt_s = $signed(src_a) < $signed(src_b);
    lt_u = src_a < src_b;
    mn_s = lt_s ? src_a : src_b;
    mx_s = lt_s ? src_b : src_a;
    mn_u = lt_u ? src_a : src_b;
    mx_u = lt_u ? src_b : src_a;
  end

  // result select
  always_comb begin
    result     = '0;
    illegal_op = 1'b0;
    case (op)
      OP_ANDN:  result = src_a & ~src_b;
      OP_ORN:   result = src_a | ~src_b;
      OP_XNOR:  result = ~(src_a ^ src_b);
      OP_CLZ:   result = XLEN'(f_lz);
      OP_CTZ:   result = XLEN'(f_tz);
      OP_CPOP:  result = XLEN'(f_pop);
      OP_MIN:   result = mn_s;
      OP_MINU:  result = mn_u;
      OP_MAX:   result = mx_s;
      OP_MAXU:  result = mx_u;
      OP_ROL:   result = f_rol;
      OP_ROR,
      OP_RORI:  result = f_ror;
      OP_REV8:  result = b_rev;
      OP_ORCB:  result = b_orc;
      OP_SEXTB: result = b_sxb;
      OP_SEXTH: result = b_sxh;
      OP_ZEXTH: result = b_zxh;
      OP_CLZW:  if (HAS_WORD) result = w_clz; else illegal_op = 1'b1;
      OP_CTZW:  if (HAS_WORD) result = w_ctz; else illegal_op = 1'b1;
      OP_CPOPW: if (HAS_WORD) result = w_pop; else illegal_op = 1'b1;
      OP_ROLW:  if (HAS_WORD) result = w_rol; else illegal_op = 1'b1;
      OP_RORW,
      OP_RORIW: if (HAS_WORD) result = w_ror; else illegal_op = 1'b1;
      default:  illegal_op = 1'b1;
    endcase
  end

  always_comb begin
    if (illegal_op) begin
      AST_ILLEGAL_ZERO: assert (result == '0)
        else $error("illegal op with nonzero result"); // R10
    end
    if (op_sel > 5'd23) begin
      AST_UNASSIGNED_FLAG: assert (illegal_op)
        else $error("unassigned code not flagged"); // R10
    end
    if (op == OP_CLZ && src_a != '0) begin
      AST_CLZ_LEAD_ONE: assert ((src_a >> (XLEN - 1 - int'(result))) == XLEN'(1))
        else $error("leading-zero count misplaced"); // R2
    end
    if (op == OP_CPOP) begin
      AST_CPOP_MATCH: assert (result == XLEN'($countones(src_a)))
        else $error("population count mismatch"); // R3
    end
    if (op == OP_MIN || op == OP_MINU || op == OP_MAX || op == OP_MAXU) begin
      AST_MINMAX_PICK: assert (result == src_a || result == src_b)
        else $error("min/max returned neither operand"); // R5
    end
    if (op == OP_ROL || op == OP_ROR || op == OP_RORI) begin
      AST_ROT_POP: assert ($countones(result) == $countones(src_a))
        else $error("rotate changed bit count"); // R6
    end
  end

endmodule

// File: tb/bmu_alu_bench.sv
module bmu_alu_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [4:0]  op_sel;
  logic [63:0] src_a, src_b;
  logic [5:0]  shamt;
  logic [63:0] res64;
  logic        ill64;
  logic [31:0] res32;
  logic        ill32;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;
  bit done     = 1'b0;

  bmu_alu #(.XLEN(64)) u_bmu_alu (
    .op_sel(op_sel), .src_a(src_a), .src_b(src_b), .shamt(shamt),
    .result(res64), .illegal_op(ill64)
  );

  bmu_alu #(.XLEN(32)) u_bmu_alu_w32 (
    .op_sel(op_sel), .src_a(src_a[31:0]), .src_b(src_b[31:0]), .shamt(shamt),
    .result(res32), .illegal_op(ill32)
  );

  function automatic string req_of(logic [4:0] op);
    case (op)
      5'd0, 5'd1, 5'd2:                  return "R1";
      5'd3, 5'd4:                        return "R2";
      5'd5:                              return "R3";
      5'd6, 5'd7, 5'd8:                  return "R4";
      5'd9, 5'd10, 5'd11, 5'd12:         return "R5";
      5'd13, 5'd14, 5'd15:               return "R6";
      5'd16, 5'd17, 5'd18:               return "R7";
      5'd19, 5'd20:                      return "R8";
      5'd21, 5'd22, 5'd23:               return "R9";
      default:                           return "R10";
    endcase
  endfunction

  function automatic logic [63:0] rot_r(logic [63:0] v, int amt, int w);
    logic [63:0] r = '0;
    for (int i = 0; i < w; i++) r[i] = v[(i + amt) % w];
    return r;
  endfunction

  function automatic logic [63:0] rot_l(logic [63:0] v, int amt, int w);
    logic [63:0] r = '0;
    for (int i = 0; i < w; i++) r[(i + amt) % w] = v[i];
    return r;
  endfunction

  function automatic int lead0(logic [63:0] v, int w);
    for (int i = w - 1; i >= 0; i--) if (v[i]) return w - 1 - i;
    return w;
  endfunction

  function automatic int trail0(logic [63:0] v, int w);
    for (int i = 0; i < w; i++) if (v[i]) return i;
    return w;
  endfunction

  function automatic logic [63:0] sx32(logic [63:0] v);
    return {{32{v[31]}}, v[31:0]};
  endfunction

  // returns {illegal, result}
  function automatic logic [64:0] ref_op(int xl, logic [4:0] op, logic [63:0] a_in,
                                         logic [63:0] b_in, logic [5:0] sh);
    logic [63:0] m = (xl == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0000_0000_FFFF_FFFF;
    logic [63:0] a = a_in & m;
    logic [63:0] b = b_in & m;
    logic [63:0] sa = (xl == 64) ? a : sx32(a);
    logic [63:0] sb = (xl == 64) ? b : sx32(b);
    logic [63:0] lw = {32'd0, a[31:0]};
    logic [63:0] r = '0;
    logic ill = 1'b0;
    bit wide = (xl == 64);
    case (op)
      5'd0:  r = a & ~b;
      5'd1:  r = a | ~b;
      5'd2:  r = ~(a ^ b);
      5'd3:  r = 64'(lead0(a, xl));
      5'd4:  r = 64'(trail0(a, xl));
      5'd5:  r = 64'($countones(a));
      5'd6:  if (wide) r = 64'(lead0(lw, 32)); else ill = 1'b1;
      5'd7:  if (wide) r = 64'(trail0(lw, 32)); else ill = 1'b1;
      5'd8:  if (wide) r = 64'($countones(lw)); else ill = 1'b1;
      5'd9:  r = ($signed(sa) < $signed(sb)) ? a : b;
      5'd10: r = (a < b) ? a : b;
      5'd11: r = ($signed(sa) < $signed(sb)) ? b : a;
      5'd12: r = (a < b) ? b : a;
      5'd13: r = rot_l(a, int'(b % 64'(xl)), xl);
      5'd14: r = rot_r(a, int'(b % 64'(xl)), xl);
      5'd15: r = rot_r(a, int'(sh) % xl, xl);
      5'd16: if (wide) r = sx32(rot_l(lw, int'(b % 64'd32), 32)); else ill = 1'b1;
      5'd17: if (wide) r = sx32(rot_r(lw, int'(b % 64'd32), 32)); else ill = 1'b1;
      5'd18: if (wide) r = sx32(rot_r(lw, int'(sh) % 32, 32)); else ill = 1'b1;
      5'd19: for (int k = 0; k < xl / 8; k++) r[k*8 +: 8] = a[(xl/8-1-k)*8 +: 8];
      5'd20: for (int k = 0; k < xl / 8; k++) r[k*8 +: 8] = (a[k*8 +: 8] != 8'd0) ? 8'hFF : 8'h00;
      5'd21: r = {{56{a[7]}}, a[7:0]};
      5'd22: r = {{48{a[15]}}, a[15:0]};
      5'd23: r = {48'd0, a[15:0]};
      default: ill = 1'b1;
    endcase
    if (ill) r = '0;
    return {ill, r & m};
  endfunction

  task automatic check_one(logic [4:0] op, logic [63:0] a, logic [63:0] b, logic [5:0] sh);
    logic [64:0] e64, e32;
    @(negedge clk);
    op_sel = op; src_a = a; src_b = b; shamt = sh;
    #1;
    e64 = ref_op(64, op, a, b, sh);
    e32 = ref_op(32, op, a, b, sh);
    n_checks++;
    if ({ill64, res64} !== e64) begin
      n_fail++;
      $display("FAIL %s op=%0d xlen64 a=%h b=%h sh=%0d actual ill=%b res=%h expected ill=%b res=%h",
               req_of(op), op, a, b, sh, ill64, res64, e64[64], e64[63:0]);
    end
    n_checks++;
    if ({ill32, res32} !== {e32[64], e32[31:0]}) begin
      n_fail++;
      $display("FAIL %s op=%0d xlen32 a=%h b=%h sh=%0d actual ill=%b res=%h expected ill=%b res=%h",
               req_of(op), op, a[31:0], b[31:0], sh, ill32, res32, e32[64], e32[31:0]);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual cycles=%0d expected below 150000", cycles);
      finish_run();
    end
  end

  function automatic logic [63:0] shaped(int kind);
    case (kind)
      0: return 64'd0;
      1: return {$urandom, $urandom};
      2: return 64'(1) << ($urandom % 64);
      3: return {32'(~$urandom), 32'd0};
      4: return 64'(~0) >> ($urandom % 64);
      default: return {$urandom, $urandom} & {$urandom, $urandom};
    endcase
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    op_sel = '0; src_a = '0; src_b = '0; shamt = '0;
    repeat (4) @(posedge clk);
    rst_n = 1'b1;

    // idle/reset-state check: all-zero inputs, code 0 -> zero, legal (R1)
    check_one(5'd0, 64'd0, 64'd0, 6'd0);

    // R1 inverted-operand logic
    check_one(5'd0, 64'hF0F0_1234_FFFF_0000, 64'h0FF0_00FF_F0F0_FFFF, 6'd0);
    check_one(5'd1, 64'h0000_0000_0000_0001, 64'hFFFF_0000_FFFF_0000, 6'd0);
    check_one(5'd2, 64'hAAAA_5555_AAAA_5555, 64'hAAAA_AAAA_5555_5555, 6'd0);
    // R2 zero operand and extremes
    check_one(5'd3, 64'd0, 64'd0, 6'd0);
    check_one(5'd4, 64'd0, 64'd0, 6'd0);
    check_one(5'd3, 64'h8000_0000_0000_0000, 64'd0, 6'd0);
    check_one(5'd4, 64'h8000_0000_0000_0000, 64'd0, 6'd0);
    // R3
    check_one(5'd5, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 6'd0);
    // R4 upper bits ignored, zero low word gives 32
    check_one(5'd6, 64'hFFFF_FFFF_0000_0000, 64'd0, 6'd0);
    check_one(5'd7, 64'hFFFF_FFFF_0000_0000, 64'd0, 6'd0);
    check_one(5'd8, 64'hFFFF_FFFF_0000_00F1, 64'd0, 6'd0);
    // R5 sign boundary
    check_one(5'd9,  64'h8000_0000_8000_0000, 64'd1, 6'd0);
    check_one(5'd10, 64'h8000_0000_8000_0000, 64'd1, 6'd0);
    check_one(5'd11, 64'h8000_0000_8000_0000, 64'd1, 6'd0);
    check_one(5'd12, 64'h8000_0000_8000_0000, 64'd1, 6'd0);
    // R6 amounts at and beyond width
    check_one(5'd13, 64'h8000_0000_0000_0001, 64'd64, 6'd0);
    check_one(5'd14, 64'h8000_0000_0000_0001, 64'd65, 6'd0);
    check_one(5'd15, 64'h0123_4567_89AB_CDEF, 64'd0, 6'd63);
    check_one(5'd15, 64'h0123_4567_89AB_CDEF, 64'd0, 6'd36);
    // R7 word rotates with junk upper bits and sign change
    check_one(5'd16, 64'hDEAD_BEEF_4000_0000, 64'd33, 6'd0);
    check_one(5'd17, 64'hDEAD_BEEF_0000_0001, 64'd1, 6'd0);
    check_one(5'd18, 64'h1234_5678_0000_0001, 64'd0, 6'd33);
    // R8
    check_one(5'd19, 64'h0102_0304_0506_0708, 64'd0, 6'd0);
    check_one(5'd20, 64'h0100_8000_0000_0001, 64'd0, 6'd0);
    // R9
    check_one(5'd21, 64'h1234_5678_9ABC_DE80, 64'd0, 6'd0);
    check_one(5'd22, 64'h1234_5678_9ABC_8001, 64'd0, 6'd0);
    check_one(5'd23, 64'h1234_5678_9ABC_8001, 64'd0, 6'd0);
    // R10 unassigned codes
    for (int c = 24; c < 32; c++) check_one(5'(c), 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 6'd5);

    // seeded random mix over all codes
    for (int it = 0; it < 6000; it++) begin
      check_one(5'($urandom % 32), shaped(int'($urandom % 6)), shaped(int'($urandom % 6)),
                6'($urandom));
    end

    done = 1'b1;
    finish_run();
  end

endmodule